// File: doc/BRIEF.md
# Scanline Sync and NMI Generator

This block sets the horizontal timing of a small home-computer video circuit. It runs on the CPU clock. A line counter runs all the time and returns to zero by itself at the end of each scanline period. A horizontal sync pulse, active low, is placed at a fixed offset after every counter restart. While software has enabled it, a non-maskable interrupt request of the same shape goes to the CPU alongside each sync pulse. This is how the display routine is paced line by line.

The CPU can pull the counter back into step with its own execution. When it performs an interrupt-acknowledge cycle, which the block sees as its M1 and IORQ strobes both low in the same clock, the counter restarts at zero. Software can switch the NMI off and on again with two single-cycle strobes. The sync output cannot be switched off. The counter position is brought out so that it can be observed.

Top module: `scan_sync_gen`

## Requirements
- R1: With no acknowledge, `line_pos` steps by one on each clock through 0 to LINE_LEN-1 (default 206). It then returns to 0, giving a period of LINE_LEN clocks.
- R2: When `m1_n` and `iorq_n` are sampled low together on a clock edge that starts an acknowledge, `line_pos` reads 0 after that edge. If only one of the two strobes is low, the counter is not disturbed.
- R3: `hsync_n` is low exactly while `line_pos` lies in SYNC_DLY to SYNC_DLY+SYNC_LEN-1 (default 16 to 31). The pulse therefore starts 16 clocks after any restart and lasts 16 clocks.
- R4: An acknowledge that is held low for several clocks restarts the counter only on its first clock. After that the counter keeps counting up.
- R5: If an acknowledge arrives while `hsync_n` is low, `hsync_n` is high and `line_pos` is 0 on the next clock. A new pulse follows SYNC_DLY clocks later.
- R6: `nmi_n` is low exactly in the clocks where `hsync_n` is low and the NMI enable is set.
- R7: A pulse on `nmi_on` sets the enable and a pulse on `nmi_off` clears it. Each takes effect from the next clock. If both pulse in the same clock, the enable ends up cleared.
- R8: `hsync_n` timing does not depend on the NMI enable or on the two enable strobes.
- R9: While `rst` is high, after each clock `line_pos` is 0, `hsync_n` and `nmi_n` are high, and the enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| m1_n | input | 1 | CPU M1 strobe, active low |
| iorq_n | input | 1 | CPU IORQ strobe, active low |
| nmi_on | input | 1 | Single-cycle strobe that enables NMI |
| nmi_off | input | 1 | Single-cycle strobe that disables NMI |
| hsync_n | output | 1 | Horizontal sync to the video output, active low |
| nmi_n | output | 1 | NMI request to the CPU, active low |
| line_pos | output | $clog2(LINE_LEN) | Current line counter value |

## Verification
The hardest condition to reach from the ports is an acknowledge that lands in the middle of a sync pulse. The same goes for one held over several clocks, as happens when wait states stretch the cycle. The bench watches `line_pos` until it reaches a chosen point inside the pulse window and only then lowers both strobes. It holds them for a different run of clocks in a separate phase. The stimulus also lowers each strobe on its own, and issues conflicting enable strobes in the same clock. Throughout, a behavioural model checks every output on every clock.

// File: rtl/scan_sync_pkg.sv
package scan_sync_pkg;

    // Why the counter took its next value
    typedef enum logic [1:0] {
        STEP_COUNT = 2'd0,
        STEP_WRAP  = 2'd1,
        STEP_ACK   = 2'd2
    } step_cause_e;

    // Registered output pair produced each clock
    typedef struct packed {
        logic sync_low;
        logic nmi_low;
    } pulse_pair_t;

    // True when a line position falls inside the sync window
    function automatic logic in_sync_window(input int unsigned pos,
                                            input int unsigned dly,
                                            input int unsigned len);
        return (pos >= dly) && (pos < dly + len);
    endfunction

endpackage

// File: rtl/ack_detect.sv
module ack_detect (
    input  logic clk,
    input  logic rst,
    input  logic m1_n,
    input  logic iorq_n,
    output logic restart_o
);
    logic ack_now;
    logic ack_seen_q;

    assign ack_now   = !m1_n && !iorq_n;
    assign restart_o = ack_now && !ack_seen_q;

    always_ff @(posedge clk) begin
        if (rst) ack_seen_q <= 1'b0;
        else     ack_seen_q <= ack_now;
    end

    // R4
    single_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart_o |=> !restart_o);

endmodule

// File: rtl/line_counter.sv
module line_counter
    import scan_sync_pkg::*;
#(
    parameter int unsigned LINE_LEN = 207,
    parameter int unsigned SYNC_DLY = 16,
    parameter int unsigned SYNC_LEN = 16,
    localparam int unsigned POS_W   = $clog2(LINE_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    output logic [POS_W-1:0] pos_o,
    output logic             win_nxt_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(LINE_LEN - 1);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_nxt;
    step_cause_e      cause;

    always_comb begin
        if (restart_i)             cause = STEP_ACK;
        else if (pos_q == LAST_POS) cause = STEP_WRAP;
        else                        cause = STEP_COUNT;

        unique case (cause)
            STEP_ACK, STEP_WRAP: pos_nxt = '0;
            default:             pos_nxt = pos_q + POS_W'(1);
        endcase
        if (rst) pos_nxt = '0;
    end

    assign win_nxt_o = in_sync_window(int'(pos_nxt), SYNC_DLY, SYNC_LEN);

    always_ff @(posedge clk) begin
        pos_q <= pos_nxt;
    end

    assign pos_o = pos_q;

    // R1
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_q == LAST_POS) |=> (pos_q == '0));

    // R1
    pos_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST_POS);

    // R2
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (pos_q == '0));

endmodule

// File: rtl/nmi_gate.sv
module nmi_gate
    import scan_sync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nmi_on,
    input  logic nmi_off,
    input  logic win_nxt_i,
    output logic hsync_n_o,
    output logic nmi_n_o
);
    logic        en_q;
    logic        en_nxt;
    pulse_pair_t pair_nxt;
    pulse_pair_t pair_q;

    always_comb begin
        en_nxt = en_q;
        if (nmi_on)  en_nxt = 1'b1;
        if (nmi_off) en_nxt = 1'b0;
        pair_nxt.sync_low = win_nxt_i;
        pair_nxt.nmi_low  = win_nxt_i && en_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pair_q <= '0;
        end else begin
            en_q   <= en_nxt;
            pair_q <= pair_nxt;
        end
    end

    assign hsync_n_o = !pair_q.sync_low;
    assign nmi_n_o   = !pair_q.nmi_low;

    // R7
    off_quiets_nmi_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_off |=> nmi_n_o);

    // R6
    nmi_within_sync_chk: assert property (@(posedge clk) disable iff (rst)
        !nmi_n_o |-> !hsync_n_o);

endmodule

// File: rtl/scan_sync_gen.sv
module scan_sync_gen #(
    parameter int unsigned LINE_LEN = 207,
    parameter int unsigned SYNC_DLY = 16,
    parameter int unsigned SYNC_LEN = 16,
    localparam int unsigned POS_W   = $clog2(LINE_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             m1_n,
    input  logic             iorq_n,
    input  logic             nmi_on,
    input  logic             nmi_off,
    output logic             hsync_n,
    output logic             nmi_n,
    output logic [POS_W-1:0] line_pos
);
    logic restart;
    logic win_nxt;

    ack_detect u_ack (
        .clk       (clk),
        .rst       (rst),
        .m1_n      (m1_n),
        .iorq_n    (iorq_n),
        .restart_o (restart)
    );

    line_counter #(
        .LINE_LEN (LINE_LEN),
        .SYNC_DLY (SYNC_DLY),
        .SYNC_LEN (SYNC_LEN)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .pos_o     (line_pos),
        .win_nxt_o (win_nxt)
    );

    nmi_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .nmi_on    (nmi_on),
        .nmi_off   (nmi_off),
        .win_nxt_i (win_nxt),
        .hsync_n_o (hsync_n),
        .nmi_n_o   (nmi_n)
    );

    // R3
    sync_start_pos_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |-> (line_pos == POS_W'(SYNC_DLY)));

    // R5
    ack_ends_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (!hsync_n && restart) |=> hsync_n);

endmodule

// File: tb/tb_scan_sync_gen.sv
module tb_scan_sync_gen;
    localparam int LINE_LEN = 207;
    localparam int SYNC_DLY = 16;
    localparam int SYNC_LEN = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m1_n = 1'b1;
    logic       iorq_n = 1'b1;
    logic       nmi_on = 1'b0;
    logic       nmi_off = 1'b0;
    logic       hsync_n;
    logic       nmi_n;
    logic [7:0] line_pos;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    // Reference state
    int m_pos = 0;
    bit m_en = 0;
    bit m_ack_prev = 0;

    always #2 clk = ~clk;

    scan_sync_gen dut (
        .clk(clk), .rst(rst), .m1_n(m1_n), .iorq_n(iorq_n),
        .nmi_on(nmi_on), .nmi_off(nmi_off),
        .hsync_n(hsync_n), .nmi_n(nmi_n), .line_pos(line_pos)
    );

    // Behavioural model advanced on every edge
    always @(posedge clk) begin
        bit ack;
        ack = (m1_n == 1'b0) && (iorq_n == 1'b0);
        cycles++;
        if (rst) begin
            m_pos = 0; m_en = 0; m_ack_prev = 0;
        end else begin
            if (ack && !m_ack_prev)      m_pos = 0;
            else if (m_pos == LINE_LEN-1) m_pos = 0;
            else                          m_pos = m_pos + 1;
            if (nmi_on)  m_en = 1;
            if (nmi_off) m_en = 0;
            m_ack_prev = ack;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    task automatic tick();
        bit win;
        @(negedge clk);
        win = (m_pos >= SYNC_DLY) && (m_pos < SYNC_DLY + SYNC_LEN);
        chk("R1 line_pos", int'(line_pos), m_pos);
        chk("R3 hsync_n", int'(hsync_n), win ? 0 : 1);
        chk("R6 nmi_n", int'(nmi_n), (win && m_en) ? 0 : 1);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        run(3);
        // R9 reset state
        chk("R9 line_pos", int'(line_pos), 0);
        chk("R9 hsync_n", int'(hsync_n), 1);
        chk("R9 nmi_n", int'(nmi_n), 1);
        rst = 1'b0;

        // R1 free running over two lines
        run(2 * LINE_LEN + 30);

        // R2 one strobe alone does nothing
        m1_n = 1'b0; run(3); m1_n = 1'b1;
        iorq_n = 1'b0; run(3); iorq_n = 1'b1;
        run(40);
        m1_n = 1'b0; iorq_n = 1'b0; tick();
        chk("R2 restart", int'(line_pos), 0);
        m1_n = 1'b1; iorq_n = 1'b1;
        run(60);

        // R4 held acknowledge restarts once
        m1_n = 1'b0; iorq_n = 1'b0;
        run(5);
        chk("R4 held ack", int'(line_pos), 4);
        m1_n = 1'b1; iorq_n = 1'b1;
        run(LINE_LEN);

        // R7 enable, then conflicting strobes
        nmi_on = 1'b1; tick(); nmi_on = 1'b0;
        run(LINE_LEN + 10);
        nmi_on = 1'b1; nmi_off = 1'b1; tick();
        nmi_on = 1'b0; nmi_off = 1'b0;
        while (line_pos != 8'(SYNC_DLY + 2)) tick();
        chk("R7 both strobes, nmi_n", int'(nmi_n), 1);
        nmi_on = 1'b1; tick(); nmi_on = 1'b0;
        run(LINE_LEN);

        // R5 acknowledge in the middle of a pulse
        while (line_pos != 8'(SYNC_DLY + 4)) tick();
        chk("R5 in pulse", int'(hsync_n), 0);
        m1_n = 1'b0; iorq_n = 1'b0; tick();
        m1_n = 1'b1; iorq_n = 1'b1;
        chk("R5 pos", int'(line_pos), 0);
        chk("R5 hsync_n", int'(hsync_n), 1);
        run(SYNC_DLY);
        chk("R5 new pulse", int'(hsync_n), 0);
        run(LINE_LEN);

        // R8 sync keeps running with NMI off
        nmi_off = 1'b1; tick(); nmi_off = 1'b0;
        while (line_pos != 8'(SYNC_DLY)) tick();
        chk("R8 hsync_n", int'(hsync_n), 0);
        chk("R8 nmi_n", int'(nmi_n), 1);
        run(LINE_LEN + 20);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule